// File: doc/BRIEF.md
# Overlapping-Carrier Five-Level PWM Comparator

This block produces the level-select pulses for one leg of a five-level cascaded H-bridge converter. Every clock it compares one signed reference sample with four triangular carriers. All four carriers have the same period and the same height. Each carrier sits half its height above the one below it, so neighbouring bands overlap by half. The reference is measured from the centre of the combined band. The block reports the four comparator results and the level they select, from -2 to +2 DC steps.

One shared up/down counter forms all four carriers. A carrier is either the counter value or its mirror, and a two-bit arrangement code picks which carriers are mirrored. In the first pattern all carriers are in phase. In the second, the upper pair is in antiphase with the lower pair. In the third, every other carrier is inverted. A new arrangement code takes effect only when the counter turns, so a carrier never jumps in the middle of a slope. The turn is also signalled on a strobe output, which lets the reference source stay in step with the carriers.

Top module: `ovl_pwm_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cmp_o` is 0000, `level_o` is 0 and `peak_o` is 0. When reset is released the counter stands at 0 and counts upward, and the arrangement is in-phase.
- R2: With half period N (N ≥ 2) the counter steps 0,1,…,N,N-1,…,0,1,… and so has period 2N. A turn happens in a cycle where the counter is counting up and has reached N, or is counting down and has reached 0. `peak_o` is 1 for exactly the one cycle that follows each turn.
- R3: Carrier k (k = 0..3, bit k of `cmp_o`) is compared in units scaled by four. Bit k is 1 when 4·ref + 5·N ≥ 2·k·N + 4·c_k. Here c_k is the counter value, or N minus the counter value when carrier k is inverted. Equality counts as a 1, and this relation holds for any N.
- R4: Arrangement code 0, and the spare code 3, invert no carrier.
- R5: Arrangement code 1 inverts carriers 2 and 3 and leaves carriers 0 and 1 as they are.
- R6: Arrangement code 2 inverts carriers 1 and 3.
- R7: Both outputs are registered and use the same sample. `cmp_o` and `level_o` in a given cycle reflect the reference, the half period and the counter state of the cycle before. `level_o` equals the number of set bits in `cmp_o` minus 2.
- R8: The arrangement code is sampled only in a turn cycle. A code presented at any other time has no effect on `cmp_o` until the next turn.
- R9: A reference at or above +5N/4 sets all four bits (level +2). A reference below -5N/4 clears all four bits (level -2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_period_i | input | CNT_W | Half carrier period N in clocks (N ≥ 2) |
| arrange_i | input | 2 | Requested carrier arrangement: 0 in phase, 1 group antiphase, 2 alternate, 3 spare (in phase) |
| ref_i | input | REF_W | Signed reference sample, zero at the centre of the carrier span |
| cmp_o | output | 4 | Registered comparator bits, bit k for carrier k from the bottom |
| level_o | output | 3 | Registered signed output level, -2 to +2 |
| peak_o | output | 1 | One-cycle strobe following each counter turn |

## Verification
The hardest case to reach is an arrangement request that arrives part way along a slope. The bench must show that the request is held back until the counter turns, and that it then takes effect without a glitch. To get there, the stimulus changes the code while the counter is in mid-ramp and checks every cycle against a reference model. The model latches the code only on a turn. Ties between the reference and a carrier are reached with a sweep in steps that match the scaled carrier grid. An odd half period is also used, reached after the counter has returned to zero, so that the half-step offsets no longer divide evenly.

// File: rtl/ovl_pwm_pkg.sv
`timescale 1ns/1ps
package ovl_pwm_pkg;
  localparam int NCAR = 4;

  typedef enum logic [1:0] {
    ARR_INPHASE = 2'd0,
    ARR_GROUPS  = 2'd1,
    ARR_ALTERN  = 2'd2,
    ARR_SPARE   = 2'd3
  } arr_e;

  // true when carrier k is the mirrored ramp under arrangement a
  function automatic logic carrier_inverted(arr_e a, int k);
    case (a)
      ARR_GROUPS: return k >= NCAR / 2;
      ARR_ALTERN: return (k % 2) == 1;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ovl_tri_counter.sv
`timescale 1ns/1ps
module ovl_tri_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             turn_o,
  output logic             peak_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             peak_q;
  logic             turn;

  assign turn = up_q ? (cnt_q >= half_i) : (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      peak_q <= 1'b0;
    end else begin
      peak_q <= turn;
      if (turn) begin
        up_q  <= ~up_q;
        cnt_q <= up_q ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end else begin
        cnt_q <= up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign turn_o = turn;
  assign peak_o = peak_q;

  // R2: strobe never lasts two cycles for a legal half period
  assert_peak_single_R2: assert property (@(posedge clk) disable iff (rst)
    (peak_q && half_i >= 2 && $stable(half_i)) |=> !peak_q);

  // R2: ramp stays inside [0, N] while N is held
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= half_i && $stable(half_i)) |=> (cnt_q <= half_i));
endmodule

// File: rtl/ovl_arrangement.sv
`timescale 1ns/1ps
module ovl_arrangement
  import ovl_pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            turn_i,
  input  logic [1:0]      arr_req_i,
  output logic [NCAR-1:0] inv_o
);
  arr_e act_q;

  always_ff @(posedge clk) begin
    if (rst)         act_q <= ARR_INPHASE;
    else if (turn_i) act_q <= arr_e'(arr_req_i);
  end

  for (genvar k = 0; k < NCAR; k++) begin : g_inv
    assign inv_o[k] = carrier_inverted(act_q, k);
  end

  // R8: mirror pattern only moves at a counter turn
  assert_arr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !turn_i |=> $stable(inv_o));
endmodule

// File: rtl/ovl_cmp_bank.sv
`timescale 1ns/1ps
module ovl_cmp_bank
  import ovl_pwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        half_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [NCAR-1:0]         inv_i,
  output logic [NCAR-1:0]         cmp_o,
  output logic signed [2:0]       level_o
);
  localparam int CMP_W = ((REF_W + 2 > CNT_W + 4) ? REF_W + 2 : CNT_W + 4) + 2;

  logic signed [CMP_W-1:0] n_ext;
  logic signed [CMP_W-1:0] ref_ext;
  logic signed [CMP_W-1:0] lhs;
  logic [NCAR-1:0]         hit;
  logic [3:0]              ones;
  logic signed [2:0]       level_d;
  logic [NCAR-1:0]         cmp_q;
  logic signed [2:0]       lvl_q;

  assign n_ext   = signed'(CMP_W'(half_i));
  assign ref_ext = CMP_W'(ref_i);
  // reference lifted to the span centre (5N/4), everything scaled by 4
  assign lhs     = (ref_ext <<< 2) + (n_ext <<< 2) + n_ext;

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic [CNT_W-1:0]        car_cnt;
    logic signed [CMP_W-1:0] rhs;
    assign car_cnt = inv_i[k] ? half_i - cnt_i : cnt_i;
    assign rhs     = n_ext * signed'(CMP_W'(2 * k)) + (signed'(CMP_W'(car_cnt)) <<< 2);
    assign hit[k]  = lhs >= rhs;
  end

  always_comb begin
    ones = '0;
    for (int k = 0; k < NCAR; k++) ones = ones + 4'(hit[k]);
    level_d = 3'(signed'(ones) - 4'sd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      lvl_q <= '0;
    end else begin
      cmp_q <= hit;
      lvl_q <= level_d;
    end
  end

  assign cmp_o   = cmp_q;
  assign level_o = lvl_q;

  // R9: reference above every carrier top forces all bits set
  assert_overmod_high_R9: assert property (@(posedge clk) disable iff (rst)
    (lhs >= (n_ext <<< 3) + (n_ext <<< 1) && cnt_i <= half_i) |=> (cmp_o == '1));

  // R9: reference below the span bottom clears all bits
  assert_overmod_low_R9: assert property (@(posedge clk) disable iff (rst)
    (lhs < 0) |=> (cmp_o == '0));
endmodule

// File: rtl/ovl_pwm_top.sv
`timescale 1ns/1ps
module ovl_pwm_top
  import ovl_pwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        half_period_i,
  input  logic [1:0]              arrange_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [NCAR-1:0]         cmp_o,
  output logic signed [2:0]       level_o,
  output logic                    peak_o
);
  logic [CNT_W-1:0] cnt;
  logic             turn;
  logic [NCAR-1:0]  inv;

  ovl_tri_counter #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst(rst), .half_i(half_period_i),
    .cnt_o(cnt), .turn_o(turn), .peak_o(peak_o)
  );

  ovl_arrangement u_arr (
    .clk(clk), .rst(rst), .turn_i(turn), .arr_req_i(arrange_i), .inv_o(inv)
  );

  ovl_cmp_bank #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
    .clk(clk), .rst(rst), .ref_i(ref_i), .half_i(half_period_i),
    .cnt_i(cnt), .inv_i(inv), .cmp_o(cmp_o), .level_o(level_o)
  );

  // R1: a reset cycle leaves every output cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cmp_o == '0 && level_o == 3'sd0 && !peak_o));

  // R7: level tracks the registered bit count
  assert_level_count_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (32'(level_o) + 2 == $countones(cmp_o)));
endmodule

// File: tb/ovl_pwm_top_tb_top.sv
`timescale 1ns/1ps
module ovl_pwm_top_tb_top;
  localparam int CNT_W = 12;
  localparam int REF_W = 16;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [CNT_W-1:0]        half_period_i = 12'd8;
  logic [1:0]              arrange_i = 2'd0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [3:0]              cmp_o;
  logic signed [2:0]       level_o;
  logic                    peak_o;

  always #10 clk = ~clk;

  ovl_pwm_top #(.CNT_W(CNT_W), .REF_W(REF_W)) dut_i (
    .clk(clk), .rst(rst), .half_period_i(half_period_i), .arrange_i(arrange_i),
    .ref_i(ref_i), .cmp_o(cmp_o), .level_o(level_o), .peak_o(peak_o)
  );

  typedef struct {
    logic [3:0] cmp;
    int         lvl;
    logic       pk;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errs   = 0;
  int m_cnt  = 0;
  int m_up   = 1;
  int m_arr  = 0;

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected registered result
  task automatic drive(input int r, input int arr, input int n, input string tag);
    exp_t e;
    int   turn, lhs, ones, c;
    logic inv;
    ref_i         = REF_W'(r);
    arrange_i     = 2'(arr);
    half_period_i = CNT_W'(n);
    turn = m_up ? (m_cnt >= n) : (m_cnt == 0);
    lhs  = 4 * r + 5 * n;
    ones = 0;
    for (int k = 0; k < 4; k++) begin
      inv = (m_arr == 1 && k >= 2) || (m_arr == 2 && (k % 2) == 1);
      c   = inv ? n - m_cnt : m_cnt;
      e.cmp[k] = (lhs >= 2 * k * n + 4 * c);
      ones += int'(e.cmp[k]);
    end
    e.lvl = ones - 2;
    e.pk  = 1'(turn);
    e.tag = tag;
    q.push_back(e);
    if (turn != 0) begin
      m_arr = arr;
      m_cnt = m_up ? m_cnt - 1 : m_cnt + 1;
      m_up  = 1 - m_up;
    end else begin
      m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
    end
    @(negedge clk);
    #2;
  endtask

  // monitor: compare each result one cycle after it was requested
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_int(e.tag, "cmp", int'(cmp_o), int'(e.cmp));
      check_int("R7", "level", int'(level_o), e.lvl);
      check_int("R2", "peak", int'(peak_o), int'(e.pk));
    end
  end

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check_int("R1", "cmp in reset", int'(cmp_o), 0);
    check_int("R1", "level in reset", int'(level_o), 0);
    check_int("R1", "peak in reset", int'(peak_o), 0);
    #2;
    rst = 1'b0;
    // R4: in-phase sweep, ties reached on the scaled grid
    for (int i = 0; i < 64; i++) drive(((i * 7) % 25) - 12, 0, 8, "R4");
    // R8: request group antiphase mid-slope
    for (int i = 0; i < 20; i++) drive(((i * 3) % 21) - 10, 1, 8, "R8");
    // R5: group antiphase
    for (int i = 0; i < 48; i++) drive(((i * 5) % 23) - 11, 1, 8, "R5");
    // R8: alternate request arriving mid-slope, then R6
    for (int i = 0; i < 10; i++) drive(i - 5, 2, 8, "R8");
    for (int i = 0; i < 48; i++) drive(((i * 11) % 25) - 12, 2, 8, "R6");
    // R4: spare code behaves as in phase
    for (int i = 0; i < 40; i++) drive(((i * 9) % 25) - 12, 3, 8, "R4");
    // R9: over-range both ways under alternate pattern
    for (int i = 0; i < 20; i++) drive(40, 2, 8, "R9");
    for (int i = 0; i < 20; i++) drive(-40, 2, 8, "R9");
    drive(10, 2, 8, "R9");
    drive(-11, 2, 8, "R9");
    // R3: switch to odd half period once ramp is at zero
    while (m_cnt != 0) drive(0, 1, 8, "R3");
    for (int i = 0; i < 60; i++) drive(((i * 7) % 17) - 8, 1, 5, "R3");
    for (int i = 0; i < 40; i++) drive(((i * 4) % 17) - 8, 2, 5, "R3");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule